// File: doc/BRIEF.md
# Ethernet receive destination filter

This block gives the accept or reject verdict for each received Ethernet frame. A parser upstream supplies the destination address, whether a VLAN tag was present together with its 12-bit identifier, and the frame length. The block raises `frm_valid` for one cycle with these fields. One cycle later it returns a registered verdict and a reason code.

Software-side logic programs three tables through a single write port:
- 16 exact-match address entries, each with its own valid bit.
- A 4096-bit multicast hash table.
- A 4096-bit VLAN membership table.

Static control inputs select:
- broadcast acceptance;
- promiscuous reception of multicast frames;
- promiscuous reception of all other frames;
- VLAN filtering;
- long-frame support;
- suppression of the size check;
- which 12 bits of the address the hash uses.

Frames rejected for length also produce a one-cycle event and advance a saturating counter.

Address byte order: `frm_dst[47:40]` is the first byte on the wire and `frm_dst[7:0]` is the sixth. A destination is multicast when `frm_dst[40]` is set and broadcast when all 48 bits are one.

Top module: `rx_dest_filter`

## Requirements
- R1: `vld_o` is high in exactly the cycle after each cycle in which `frm_valid` is high, and low otherwise. `accept_o`, `reason_o` and `oversize_o` describe the frame presented in that earlier cycle.
- R2: Promiscuous acceptance gives reason 1.
  - A broadcast destination is accepted when `cfg_bcast_ok` is set.
  - Any other multicast destination is accepted when `cfg_mcast_all` is set.
  - Any non-multicast destination is accepted when `cfg_ucast_all` is set.
  - A broadcast frame with `cfg_bcast_ok` clear is not accepted through `cfg_mcast_all`.
- R3: Exact-match acceptance gives reason 2. It applies when no promiscuous rule accepts and some entry has its valid bit (`wr_data[48]` on write) set and its 48 address bits equal to the destination. An entry with a clear valid bit never matches.
- R4: Hash acceptance gives reason 3. It applies when neither R2 nor R3 accepts.
  - A 16-bit value is formed as {`frm_dst[7:0]`, `frm_dst[15:8]`}.
  - That value is shifted right by 4, 3, 2 or 0 for `cfg_hash_sel` = 0, 1, 2 or 3.
  - The low 12 bits of the result form the index.
  - The frame is accepted when bit index[4:0] of hash word index[11:5] is set.
- R5: When `cfg_vlan_chk` is set and `frm_tagged` is high, the frame is rejected with reason 4 if bit `frm_vid[4:0]` of VLAN word `frm_vid[11:5]` is clear. Otherwise VLAN state has no effect.
- R6: A frame is oversize when `cfg_keep_bad` is clear and either of these holds:
  - `frm_len` > 16384;
  - `frm_len` > 1522 with `cfg_long_ok` clear.
  An oversize frame is rejected with reason 5.
- R7: `oversize_o` pulses for one cycle alongside the verdict of each oversize frame. `ovr_cnt_o` then increments by one, saturating at all ones, and holds otherwise.
- R8: Priority is oversize, then VLAN reject, then promiscuous, exact, hash. A frame matching none of these gets reason 0. `accept_o` is high exactly for reasons 1, 2 and 3.
- R9: Writes use `wr_sel` 0 for an exact entry (index `wr_addr[3:0]`, `wr_data[48:0]`), 1 for hash word `wr_addr` and 2 for VLAN word `wr_addr` (both `wr_data[31:0]`). A write in the same cycle as `frm_valid` affects only later frames.
- R10: After reset, `vld_o`, `oversize_o` and `ovr_cnt_o` are zero, and all table bits, including the exact-entry valid bits, are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame fields valid, one cycle per frame |
| frm_dst | input | 48 | Destination address, first wire byte in [47:40] |
| frm_tagged | input | 1 | Frame carries a VLAN tag |
| frm_vid | input | 12 | VLAN identifier |
| frm_len | input | LEN_W | Frame length in bytes |
| cfg_bcast_ok | input | 1 | Accept broadcast |
| cfg_mcast_all | input | 1 | Accept all multicast |
| cfg_ucast_all | input | 1 | Accept all non-multicast |
| cfg_vlan_chk | input | 1 | Enable VLAN table filtering |
| cfg_long_ok | input | 1 | Allow frames up to 16384 bytes |
| cfg_keep_bad | input | 1 | Disable the size check |
| cfg_hash_sel | input | 2 | Hash bit offset selection |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table select: 0 exact, 1 hash, 2 VLAN |
| wr_addr | input | 7 | Entry or word index |
| wr_data | input | 49 | Write data; [48] is the exact-entry valid bit |
| vld_o | output | 1 | Verdict valid |
| accept_o | output | 1 | Frame accepted |
| reason_o | output | 3 | Verdict reason code |
| oversize_o | output | 1 | Oversize event |
| ovr_cnt_o | output | CNT_W | Saturating oversize count |

## Verification
The in-module assertions check the following on every cycle:
- the one-cycle verdict strobe and the absence of spurious strobes;
- the tie between `accept_o` and the reason code;
- that an oversize event never follows a frame presented with the size check disabled;
- that VLAN rejects occur only for tagged frames under filtering;
- the counter stepping, saturating or holding with the event.

Only the bench's scenarios can show the following:
- which of the overlapping rules wins for a given address;
- the exact length boundaries 1522/1523 and 16384/16385;
- hash bit selection under each offset mode;
- valid-bit skipping;
- write-versus-evaluate ordering.

The bench checks these against a bench-side model of the tables.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int N_EXACT  = 16,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 16,
  parameter int MAX_STD  = 1522,
  parameter int MAX_LONG = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [47:0]      frm_dst,
  input  logic             frm_tagged,
  input  logic [11:0]      frm_vid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             cfg_bcast_ok,
  input  logic             cfg_mcast_all,
  input  logic             cfg_ucast_all,
  input  logic             cfg_vlan_chk,
  input  logic             cfg_long_ok,
  input  logic             cfg_keep_bad,
  input  logic [1:0]       cfg_hash_sel,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [6:0]       wr_addr,
  input  logic [48:0]      wr_data,
  output logic             vld_o,
  output logic             accept_o,
  output logic [2:0]       reason_o,
  output logic             oversize_o,
  output logic [CNT_W-1:0] ovr_cnt_o
);
  localparam int IDX_W = $clog2(N_EXACT);
  localparam int WORDS = 128;
  localparam logic [LEN_W-1:0] LIM_STD  = LEN_W'(MAX_STD);
  localparam logic [LEN_W-1:0] LIM_LONG = LEN_W'(MAX_LONG);
  localparam logic [2:0] RS_MISS = 3'd0, RS_PROM = 3'd1, RS_EXACT = 3'd2,
                         RS_HASH = 3'd3, RS_VLAN = 3'd4, RS_OVS = 3'd5;

  logic [48:0] ex_tab [N_EXACT];
  logic [31:0] mc_tab [WORDS];
  logic [31:0] vl_tab [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EXACT; i++) ex_tab[i] <= '0;
      for (int i = 0; i < WORDS; i++) begin
        mc_tab[i] <= '0;
        vl_tab[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    ex_tab[wr_addr[IDX_W-1:0]] <= wr_data;
        2'd1:    mc_tab[wr_addr] <= wr_data[31:0];
        2'd2:    vl_tab[wr_addr] <= wr_data[31:0];
        default: ;
      endcase
    end
  end

  wire is_bc = &frm_dst;
  wire is_mc = frm_dst[40];
  wire promisc = is_bc ? cfg_bcast_ok : (is_mc ? cfg_mcast_all : cfg_ucast_all);

  logic [N_EXACT-1:0] ex_hits;
  for (genvar g = 0; g < N_EXACT; g++) begin : g_exact
    assign ex_hits[g] = ex_tab[g][48] && (ex_tab[g][47:0] == frm_dst);
  end
  wire ex_hit = |ex_hits;

  wire [15:0] h16 = {frm_dst[7:0], frm_dst[15:8]};
  logic [11:0] hidx;
  always_comb begin
    case (cfg_hash_sel)
      2'd0:    hidx = h16[15:4];
      2'd1:    hidx = h16[14:3];
      2'd2:    hidx = h16[13:2];
      default: hidx = h16[11:0];
    endcase
  end
  wire hash_hit = mc_tab[hidx[11:5]][hidx[4:0]];

  wire vlan_rej = cfg_vlan_chk && frm_tagged && !vl_tab[frm_vid[11:5]][frm_vid[4:0]];
  wire too_big  = !cfg_keep_bad &&
                  ((frm_len > LIM_LONG) || ((frm_len > LIM_STD) && !cfg_long_ok));

  logic [2:0] rs_nxt;
  always_comb begin
    if (too_big)       rs_nxt = RS_OVS;
    else if (vlan_rej) rs_nxt = RS_VLAN;
    else if (promisc)  rs_nxt = RS_PROM;
    else if (ex_hit)   rs_nxt = RS_EXACT;
    else if (hash_hit) rs_nxt = RS_HASH;
    else               rs_nxt = RS_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o      <= 1'b0;
      accept_o   <= 1'b0;
      reason_o   <= RS_MISS;
      oversize_o <= 1'b0;
      ovr_cnt_o  <= '0;
    end else begin
      vld_o      <= frm_valid;
      oversize_o <= frm_valid && too_big;
      if (frm_valid) begin
        reason_o <= rs_nxt;
        accept_o <= promisc || ex_hit || hash_hit ? !(too_big || vlan_rej) : 1'b0;
      end
      if (frm_valid && too_big && !(&ovr_cnt_o)) ovr_cnt_o <= ovr_cnt_o + 1'b1;
    end
  end

  p_verdict_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> vld_o);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !vld_o);
  p_accept_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (accept_o == (reason_o == RS_PROM || reason_o == RS_EXACT || reason_o == RS_HASH)));
  p_ovs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oversize_o |-> (vld_o && reason_o == RS_OVS));
  p_keep_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oversize_o |-> !$past(cfg_keep_bad));
  p_vlan_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && reason_o == RS_VLAN) |-> $past(cfg_vlan_chk && frm_tagged));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oversize_o |-> ((ovr_cnt_o == $past(ovr_cnt_o) + 1'b1) || (&$past(ovr_cnt_o) && &ovr_cnt_o)));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oversize_o |-> $stable(ovr_cnt_o));
endmodule

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;
  timeunit 1ns; timeprecision 1ps;
  localparam int CW = 4;
  localparam logic [2:0] E_MISS = 3'd0, E_PROM = 3'd1, E_EXACT = 3'd2,
                         E_HASH = 3'd3, E_VLAN = 3'd4, E_OVS = 3'd5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, frm_valid, frm_tagged;
  logic [47:0] frm_dst;
  logic [11:0] frm_vid;
  logic [15:0] frm_len;
  logic cfg_bcast_ok, cfg_mcast_all, cfg_ucast_all, cfg_vlan_chk, cfg_long_ok, cfg_keep_bad;
  logic [1:0] cfg_hash_sel;
  logic wr_en;
  logic [1:0] wr_sel;
  logic [6:0] wr_addr;
  logic [48:0] wr_data;
  logic vld_o, accept_o, oversize_o;
  logic [2:0] reason_o;
  logic [CW-1:0] ovr_cnt_o;

  rx_dest_filter #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_dst(frm_dst),
    .frm_tagged(frm_tagged), .frm_vid(frm_vid), .frm_len(frm_len),
    .cfg_bcast_ok(cfg_bcast_ok), .cfg_mcast_all(cfg_mcast_all), .cfg_ucast_all(cfg_ucast_all),
    .cfg_vlan_chk(cfg_vlan_chk), .cfg_long_ok(cfg_long_ok), .cfg_keep_bad(cfg_keep_bad),
    .cfg_hash_sel(cfg_hash_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .vld_o(vld_o), .accept_o(accept_o), .reason_o(reason_o),
    .oversize_o(oversize_o), .ovr_cnt_o(ovr_cnt_o));

  int n_cmp = 0, n_bad = 0, sh_cnt = 0;
  logic [48:0] sh_ex [16];
  logic [31:0] sh_mc [128];
  logic [31:0] sh_vl [128];
  bit pend_wr = 0;
  logic [1:0] pend_sel;
  logic [6:0] pend_addr;
  logic [48:0] pend_data;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [2:0] model(input logic [47:0] d, input bit tg, input logic [11:0] v,
                                       input logic [15:0] l);
    logic [15:0] h;
    logic [11:0] ix;
    bit prom, ex;
    h = {d[7:0], d[15:8]};
    case (cfg_hash_sel)
      2'd0: ix = 12'(h >> 4);
      2'd1: ix = 12'(h >> 3);
      2'd2: ix = 12'(h >> 2);
      default: ix = h[11:0];
    endcase
    if (&d) prom = cfg_bcast_ok;
    else if (d[40]) prom = cfg_mcast_all;
    else prom = cfg_ucast_all;
    ex = 0;
    for (int i = 0; i < 16; i++) if (sh_ex[i][48] && sh_ex[i][47:0] == d) ex = 1;
    if (!cfg_keep_bad && (l > 16384 || (l > 1522 && !cfg_long_ok))) return E_OVS;
    if (cfg_vlan_chk && tg && !sh_vl[v[11:5]][v[4:0]]) return E_VLAN;
    if (prom) return E_PROM;
    if (ex) return E_EXACT;
    if (sh_mc[ix[11:5]][ix[4:0]]) return E_HASH;
    return E_MISS;
  endfunction

  task automatic shadow_write(input logic [1:0] s, input logic [6:0] a, input logic [48:0] dt);
    case (s)
      2'd0: sh_ex[a[3:0]] = dt;
      2'd1: sh_mc[a] = dt[31:0];
      2'd2: sh_vl[a] = dt[31:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [1:0] s, input logic [6:0] a, input logic [48:0] dt);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_addr = a; wr_data = dt;
    @(negedge clk);
    wr_en = 0;
    shadow_write(s, a, dt);
  endtask

  task automatic eval(input logic [47:0] d, input bit tg, input logic [11:0] v,
                      input logic [15:0] l, input string tag);
    logic [2:0] e;
    @(negedge clk);
    frm_valid = 1; frm_dst = d; frm_tagged = tg; frm_vid = v; frm_len = l;
    e = model(d, tg, v, l);
    if (pend_wr) begin
      wr_en = 1; wr_sel = pend_sel; wr_addr = pend_addr; wr_data = pend_data;
    end
    @(negedge clk);
    frm_valid = 0; wr_en = 0;
    if (pend_wr) begin
      shadow_write(pend_sel, pend_addr, pend_data);
      pend_wr = 0;
    end
    if (e == E_OVS && sh_cnt < 15) sh_cnt++;
    check(vld_o === 1'b1, "R1 verdict strobe", 64'(vld_o), 1);
    check(reason_o === e, tag, 64'(reason_o), 64'(e));
    check(accept_o === (e == E_PROM || e == E_EXACT || e == E_HASH), "R8 accept flag",
          64'(accept_o), 64'(e == E_PROM || e == E_EXACT || e == E_HASH));
    check(oversize_o === (e == E_OVS), "R7 event", 64'(oversize_o), 64'(e == E_OVS));
    check(ovr_cnt_o === CW'(sh_cnt), "R7 counter", 64'(ovr_cnt_o), 64'(sh_cnt));
  endtask

  task automatic cfg(input bit b, input bit m, input bit u, input bit vc, input bit lo,
                     input bit kb, input logic [1:0] hs);
    cfg_bcast_ok = b; cfg_mcast_all = m; cfg_ucast_all = u;
    cfg_vlan_chk = vc; cfg_long_ok = lo; cfg_keep_bad = kb; cfg_hash_sel = hs;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "R1 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [47:0] addr_a, addr_b, dd;
    int seed;
    seed = $urandom(32'h5eed1234);
    for (int i = 0; i < 16; i++) sh_ex[i] = '0;
    for (int i = 0; i < 128; i++) begin sh_mc[i] = '0; sh_vl[i] = '0; end
    rst_n = 0; frm_valid = 0; frm_dst = '0; frm_tagged = 0; frm_vid = '0; frm_len = 16'd64;
    wr_en = 0; wr_sel = '0; wr_addr = '0; wr_data = '0;
    cfg(0, 0, 0, 0, 0, 0, 2'd0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(vld_o === 1'b0, "R10 vld after reset", 64'(vld_o), 0);
    check(oversize_o === 1'b0, "R10 event after reset", 64'(oversize_o), 0);
    check(ovr_cnt_o === '0, "R10 counter after reset", 64'(ovr_cnt_o), 0);
    eval(48'h0211_2233_4455, 0, 12'd0, 16'd64, "R10 empty tables miss");
    eval(48'hFFFF_FFFF_FFFF, 0, 12'd0, 16'd64, "R10 broadcast miss");

    cfg(0, 0, 0, 0, 0, 0, 2'd3);
    pend_wr = 1; pend_sel = 2'd1; pend_addr = 7'h2A; pend_data = 49'h10;
    eval(48'h0211_2233_4455, 0, 12'd0, 16'd64, "R9 same-cycle write unseen");
    eval(48'h0211_2233_4455, 0, 12'd0, 16'd64, "R9 write seen next frame");

    cfg(0, 0, 1, 0, 0, 0, 2'd0);
    eval(48'h0200_0000_0001, 0, 12'd0, 16'd1522, "R6 1522 fits");
    eval(48'h0200_0000_0001, 0, 12'd0, 16'd1523, "R6 1523 oversize");
    cfg(0, 0, 1, 0, 1, 0, 2'd0);
    eval(48'h0200_0000_0001, 0, 12'd0, 16'd1523, "R6 long 1523 fits");
    eval(48'h0200_0000_0001, 0, 12'd0, 16'd16384, "R6 long 16384 fits");
    eval(48'h0200_0000_0001, 0, 12'd0, 16'd16385, "R6 long 16385 oversize");
    cfg(0, 0, 1, 0, 1, 1, 2'd0);
    eval(48'h0200_0000_0001, 0, 12'd0, 16'd16385, "R6 size check off");
    @(negedge clk);
    check(vld_o === 1'b0 && oversize_o === 1'b0, "R1/R7 idle after frame", 64'({vld_o, oversize_o}), 0);

    cfg(1, 0, 0, 0, 0, 0, 2'd0);
    eval(48'hFFFF_FFFF_FFFF, 0, 12'd0, 16'd64, "R2 broadcast accept");
    cfg(0, 1, 0, 0, 0, 0, 2'd0);
    eval(48'hFFFF_FFFF_FFFF, 0, 12'd0, 16'd64, "R2 broadcast not via multicast");
    eval(48'h0100_5E00_0001, 0, 12'd0, 16'd64, "R2 multicast promiscuous");
    eval(48'h0200_0000_0009, 0, 12'd0, 16'd64, "R2 unicast not via multicast");

    addr_a = 48'h02AB_CDEF_0123;
    addr_b = 48'h0212_3456_789A;
    wr(2'd0, 7'd0, {1'b1, addr_a});
    wr(2'd0, 7'd1, {1'b0, addr_b});
    cfg(0, 0, 0, 0, 0, 0, 2'd0);
    eval(addr_a, 0, 12'd0, 16'd64, "R3 valid entry match");
    eval(addr_b, 0, 12'd0, 16'd64, "R3 invalid entry skipped");

    wr(2'd2, 7'h09, 49'h8);
    cfg(0, 0, 0, 1, 0, 0, 2'd0);
    eval(addr_a, 1, 12'h123, 16'd64, "R5 vlan member");
    eval(addr_a, 1, 12'h124, 16'd64, "R5 vlan reject");
    eval(addr_a, 0, 12'h124, 16'd64, "R5 untagged passes");
    cfg(0, 0, 0, 0, 0, 0, 2'd0);
    eval(addr_a, 1, 12'h124, 16'd64, "R5 filter off");

    cfg(0, 0, 1, 1, 0, 0, 2'd0);
    eval(addr_a, 1, 12'h124, 16'd2000, "R8 oversize over vlan");
    eval(addr_a, 1, 12'h124, 16'd64, "R8 vlan over promiscuous");

    wr(2'd1, 7'h6E, 49'h0800_0000);
    for (int m = 0; m < 4; m++) begin
      cfg(0, 0, 0, 0, 0, 0, 2'(m));
      eval(48'h02AA_BBCC_DDEE, 0, 12'd0, 16'd64, "R4 hash offset mode");
    end

    for (int i = 0; i < 16; i++) wr(2'd0, 7'(i), {1'($urandom % 4 != 0), $urandom, 16'($urandom)});
    for (int i = 0; i < 128; i++) wr(2'd1, 7'(i), 49'($urandom & $urandom & $urandom));
    for (int i = 0; i < 128; i++) wr(2'd2, 7'(i), 49'($urandom));
    for (int n = 0; n < 1500; n++) begin
      int k;
      logic [15:0] ln;
      cfg($urandom % 4 == 0, $urandom % 4 == 0, $urandom % 4 == 0, $urandom % 2 == 0,
          $urandom % 2 == 0, $urandom % 8 == 0, 2'($urandom));
      k = $urandom % 8;
      case (k)
        0: dd = 48'hFFFF_FFFF_FFFF;
        1, 2: dd = sh_ex[$urandom % 16][47:0];
        3: dd = {$urandom, 16'($urandom)} | 48'h0100_0000_0000;
        default: dd = {$urandom, 16'($urandom)} & ~48'h0100_0000_0000;
      endcase
      ln = ($urandom % 8 == 0) ? 16'($urandom % 20000) : 16'(60 + $urandom % 1440);
      if (n % 97 == 0) begin
        pend_wr = 1; pend_sel = 2'($urandom % 3); pend_addr = 7'($urandom);
        pend_data = {1'b1, $urandom, 16'($urandom)};
      end
      eval(dd, 1'($urandom), 12'($urandom), ln, "R8 random frame");
    end

    cfg(0, 0, 0, 0, 0, 0, 2'd0);
    for (int i = 0; i < 20; i++) eval(48'h0200_0000_0001, 0, 12'd0, 16'd3000, "R7 saturation run");
    check(ovr_cnt_o === {CW{1'b1}}, "R7 counter saturated", 64'(ovr_cnt_o), 64'({CW{1'b1}}));
    finish_run();
  end
endmodule